// File: doc/BRIEF.md
# Majority-Invert Two-Port Pixel Memory

This block is a small two-port buffer for packed pixel words. Each word holds several adjacent pixels. On the way into the array, the bits that share one significance across all the pixels are gathered into a digit group. Each group is then stored either as it is or inverted, whichever leaves ones in the majority. One flag bit per group records the choice and is stored beside the data.

On the way out, the read path applies each flag to undo the inversion and puts every bit back in its original pixel position. The write port and the read port are independent and may both be used in the same clock cycle. The read port also returns the raw stored form, so the stored polarity can be observed.

Top module: `mipx_mem`

## Requirements
- R1: A word read from an address equals the last word written to that address through `wr_data`.
- R2: Pixel p occupies `wr_data[p*PIX_W +: PIX_W]`. In the stored form, bit g of pixel p sits at stored bit `g*NPIX + p`, XORed with the flag of group g.
- R3: Every stored digit group of `NPIX` bits holds at least `NPIX/2` ones.
- R4: A group's flag is 1 only when its zeros strictly outnumber its ones in the written data. An equal split is stored uninverted with flag 0.
- R5: The flag of group g is stored at bit `PIX_W*NPIX + g` of the stored word.
- R6: `rd_data` and `rd_stored` show the content at `rd_addr` one clock edge after that edge samples `rd_en` high.
- R7: When a read and a write hit the same address in the same cycle, the read returns the content from before that write.
- R8: While `rd_en` is low, `rd_data` and `rd_stored` keep their values, even when `rd_addr` changes or a write occurs.
- R9: A clock edge with `rst` high clears `rd_stored` and `rd_data` to zero.
- R10: A cycle with `wr_en` low leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the read registers |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | $clog2(DEPTH) | Write address |
| wr_data | input | PIX_W*NPIX | Packed pixel word to store |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | $clog2(DEPTH) | Read address |
| rd_data | output | PIX_W*NPIX | Restored pixel word |
| rd_stored | output | PIX_W*NPIX+PIX_W | Stored form: grouped data bits, then the flags |

## Verification
The bench sweeps every 4-bit group value through every group position. This includes the 2-to-2 ties, which a design with a non-strict majority would store inverted and so get the flag wrong. A wrong gather or scatter of bit significances shows up as a stored image that does not match, even when the data round-trips. A write-first array shows up in the same-address collision, which would return the new word instead of the old one. A read register that loads while the read strobe is low shows up in the hold check, which would report the data at the new address.

// File: rtl/mi_pkg.sv
package mi_pkg;
  // Decide polarity for one digit group: invert only on a strict zero majority.
  function automatic logic invert_needed(input int ones, input int width);
    return (2 * ones) < width;
  endfunction
endpackage

// File: rtl/mi_encode.sv
module mi_encode #(
  parameter int PIX_W = 8,
  parameter int NPIX  = 4,
  localparam int DW   = PIX_W * NPIX,
  localparam int SW   = DW + PIX_W
) (
  input  logic [DW-1:0] pix,
  output logic [SW-1:0] stored
);
  for (genvar g = 0; g < PIX_W; g++) begin : g_grp
    logic [NPIX-1:0] raw;
    logic            inv;
    for (genvar p = 0; p < NPIX; p++) begin : g_pix
      assign raw[p] = pix[p*PIX_W + g];
    end
    assign inv = mi_pkg::invert_needed($countones(raw), NPIX);
    assign stored[g*NPIX +: NPIX] = raw ^ {NPIX{inv}};
    assign stored[DW + g]         = inv;
  end
endmodule

// File: rtl/mi_decode.sv
module mi_decode #(
  parameter int PIX_W = 8,
  parameter int NPIX  = 4,
  localparam int DW   = PIX_W * NPIX,
  localparam int SW   = DW + PIX_W
) (
  input  logic [SW-1:0] stored,
  output logic [DW-1:0] pix
);
  for (genvar g = 0; g < PIX_W; g++) begin : g_grp
    for (genvar p = 0; p < NPIX; p++) begin : g_pix
      assign pix[p*PIX_W + g] = stored[g*NPIX + p] ^ stored[DW + g];
    end
  end
endmodule

// File: rtl/mi_store.sv
module mi_store #(
  parameter int SW    = 40,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [SW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [SW-1:0] q
);
  logic [SW-1:0] mem [DEPTH];

  // Array write, no reset so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  // Read-first output register.
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= mem[ra];
  end

  p_reset_clear_r9: assert property (@(posedge clk) $past(rst) |-> q == '0);
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(re) && !$past(rst)) |-> $stable(q));
endmodule

// File: rtl/mipx_mem.sv
module mipx_mem #(
  parameter int PIX_W = 8,
  parameter int NPIX  = 4,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = PIX_W * NPIX,
  localparam int SW   = DW + PIX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [SW-1:0] rd_stored
);
  logic [SW-1:0] wr_st;

  mi_encode #(.PIX_W(PIX_W), .NPIX(NPIX)) enc_i (.pix(wr_data), .stored(wr_st));

  mi_store #(.SW(SW), .DEPTH(DEPTH)) store_i (
    .clk(clk), .rst(rst),
    .we(wr_en), .wa(wr_addr), .wd(wr_st),
    .re(rd_en), .ra(rd_addr), .q(rd_stored)
  );

  mi_decode #(.PIX_W(PIX_W), .NPIX(NPIX)) dec_i (.stored(rd_stored), .pix(rd_data));

  // Per-group checks on the encoder output against the raw port bits.
  for (genvar g = 0; g < PIX_W; g++) begin : g_chk
    logic [NPIX-1:0] in_grp;
    for (genvar p = 0; p < NPIX; p++) begin : g_bit
      assign in_grp[p] = wr_data[p*PIX_W + g];
    end
    p_flag_rule_r4: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> (wr_st[DW + g] == ((2 * $countones(in_grp)) < NPIX)));
    p_ones_major_r3: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> ((2 * $countones(wr_st[g*NPIX +: NPIX])) >= NPIX));
  end
endmodule

// File: tb/mipx_mem_tb_top.sv
module mipx_mem_tb_top;
  localparam int PW = 8, NP = 4, DEP = 64, AW = 6, DW = 32, SW = 40;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [SW-1:0] rd_stored;

  mipx_mem #(.PIX_W(PW), .NPIX(NP), .DEPTH(DEP)) dut_i (.*);

  logic [DW-1:0] model [DEP];
  int errors = 0, checks = 0;
  bit done = 0;

  // Word whose group g holds nibble (idx*5 + g*7 + idx/16) mod 16.
  function automatic logic [DW-1:0] mk_word(int idx);
    logic [DW-1:0] w = '0;
    for (int g = 0; g < PW; g++) begin
      logic [3:0] nib = 4'((idx*5 + g*7 + idx/16) % 16);
      for (int p = 0; p < NP; p++) w[p*PW + g] = nib[p];
    end
    return w;
  endfunction

  // Expected stored image per R2, R4, R5.
  function automatic logic [SW-1:0] exp_st(logic [DW-1:0] w);
    logic [SW-1:0] s = '0;
    for (int g = 0; g < PW; g++) begin
      int ones = 0;
      for (int p = 0; p < NP; p++) ones += int'(w[p*PW + g]);
      s[DW + g] = (ones * 2 < NP);
      for (int p = 0; p < NP; p++) s[g*NP + p] = w[p*PW + g] ^ s[DW + g];
    end
    return s;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(bit we, int wa, logic [DW-1:0] wd, bit re, int ra);
    @(negedge clk);
    wr_en = we; wr_addr = AW'(wa); wr_data = wd;
    rd_en = re; rd_addr = AW'(ra);
    @(posedge clk); #1;
  endtask

  task automatic check_read(int a, string tag);
    int low = 0;
    op(0, 0, '0, 1, a);
    chk({"R1 R6 ", tag}, 64'(rd_data), 64'(model[a]));
    chk("R2 R4 R5 stored image", 64'(rd_stored), 64'(exp_st(model[a])));
    for (int g = 0; g < PW; g++)
      if ($countones(rd_stored[g*NP +: NP]) * 2 < NP) low++;
    chk("R3 groups with ones minority", 64'(low), 64'd0);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk("R9 reset rd_stored", 64'(rd_stored), 64'd0);
    chk("R9 reset rd_data", 64'(rd_data), 64'd0);
    @(negedge clk) rst = 1'b0;

    // Sweep: every nibble value in every group position, across all addresses.
    for (int r = 0; r < 4; r++) begin
      for (int a = 0; a < DEP; a++) begin
        model[a] = mk_word(r*DEP + a);
        op(1, a, model[a], 0, 0);
      end
      for (int a = 0; a < DEP; a++) check_read(a, "sweep");
    end

    // Explicit ties (2-2 in every group) and extremes.
    model[10] = 32'h00FF00FF; op(1, 10, model[10], 0, 0); check_read(10, "tie");
    chk("R4 tie flags zero", 64'(rd_stored[SW-1:DW]), 64'd0);
    model[11] = 32'h0; op(1, 11, model[11], 0, 0); check_read(11, "all zero");
    chk("R4 all-zero flags set", 64'(rd_stored[SW-1:DW]), 64'hFF);
    model[12] = 32'hFFFFFFFF; op(1, 12, model[12], 0, 0); check_read(12, "all one");

    // R7: same-address read and write in one cycle returns old data.
    op(1, 5, 32'hA5A55A5A, 1, 5);
    chk("R7 collision old data", 64'(rd_data), 64'(model[5]));
    model[5] = 32'hA5A55A5A;
    check_read(5, "R7 after collision");

    // R8: rd_en low holds outputs despite address change and write.
    op(0, 0, '0, 1, 7);
    op(1, 7, 32'h12345678, 0, 20);
    chk("R8 hold rd_data", 64'(rd_data), 64'(model[7]));
    model[7] = 32'h12345678;
    check_read(7, "R8 later read");

    // R10: wr_en low writes nothing.
    op(0, 3, 32'hDEADBEEF, 0, 0);
    check_read(3, "R10 no write");

    // R9: reset mid-run.
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    chk("R9 mid reset rd_data", 64'(rd_data), 64'd0);
    chk("R9 mid reset rd_stored", 64'(rd_stored), 64'd0);
    @(negedge clk) rst = 1'b0;
    check_read(3, "R1 after reset");

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule